// File: doc/BRIEF.md
# Framed Command Packet Receiver

This block sits behind a serial shift register and turns its stream of received bytes into validated command packets. Bytes arrive one per cycle when `in_valid` is high. The receiver stays idle, discarding bytes, until it sees the start marker 0x82. It then takes a command byte, a length byte and as many payload bytes as the length names, followed by two check bytes.

The receiver keeps two running checksums over the protected bytes (command, length and payload, but not the marker). It compares them with the two check bytes that arrive. When both match, it raises `pkt_done` for one cycle and holds the command, length and payload on its outputs. When either check byte does not match, or the length is out of range, it raises `pkt_err` for one cycle instead. Command codes 0 to 3 have defined meanings: loopback, timecode enable, clock select and timecode report. Any other code is still delivered, but `pkt_unknown` is set with it.

Top module: `cmd_frame_rx`

## Requirements
- R1: While hunting for a packet, every byte other than 0x82 is dropped and produces neither `pkt_done` nor `pkt_err`.
- R2: After 0x82 the receiver takes the command byte, then the length byte, then that many payload bytes. Payload byte i appears on `pkt_payload[8*i+7:8*i]`, the command on `pkt_cmd` and the length on `pkt_len`.
- R3: The first check byte must equal the bitwise inverse of the XOR of the protected bytes at odd positions (1, 3, 5, ...), where the command byte is position 1.
- R4: The second check byte must equal the bitwise inverse of the XOR of the protected bytes at even positions (2, 4, ...), where the length byte is position 2.
- R5: The 0x82 marker is not part of either checksum. A 0x82 value inside the payload is treated as ordinary data.
- R6: When both check bytes match, `pkt_done` is high for exactly one cycle, in the cycle after the second check byte is accepted, and `pkt_err` stays low.
- R7: When either check byte mismatches, `pkt_err` is high for one cycle in that same cycle position, `pkt_done` stays low, and the receiver returns to hunting.
- R8: A length byte above 60 raises `pkt_err` in the cycle after it is accepted, and the receiver returns to hunting. Lengths up to and including 60 are accepted.
- R9: With a length of 0, the first check byte directly follows the length byte.
- R10: `pkt_unknown` is 1 with a delivered packet whose command is above 3, and 0 for commands 0 to 3.
- R11: Cycles with `in_valid` low are ignored at every point in a packet and do not change the result.
- R12: Reset, including reset in mid-packet, returns the receiver to hunting, clears both checksums, drives `pkt_done` and `pkt_err` low, and zeroes `pkt_cmd`, `pkt_len`, `pkt_unknown` and `pkt_payload`.
- R13: Each new packet zeroes the payload at its start, so payload bytes at or beyond the delivered length read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | `in_byte` holds a received byte this cycle |
| in_byte | input | 8 | Received byte |
| pkt_done | output | 1 | One-cycle pulse: a packet passed both checks |
| pkt_err | output | 1 | One-cycle pulse: checksum mismatch or length too large |
| pkt_cmd | output | 8 | Command byte of the current or last packet |
| pkt_len | output | 8 | Payload length of the current or last packet |
| pkt_payload | output | MAX_DATA*8 | Payload bytes, with byte 0 in the low bits |
| pkt_unknown | output | 1 | Command code above 3 |

## Verification
The hardest situations to reach are those where the receiver state and the byte values interact. One is a 0x82 byte that lands inside the payload and must not restart the frame. Another is a reset that arrives in the middle of a frame, after the checksums have already absorbed bytes. The stimulus builds both explicitly. It chooses the payload seed so that the first data byte is 0x82. It also drops reset after the command, length and part of the payload have been accepted, and then sends a clean packet that only passes if the accumulators were cleared. Separate frames corrupt only the low or only the high check byte, so that each checksum is shown to be checked on its own.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  localparam logic [7:0] START_BYTE = 8'h82;
  localparam logic [7:0] LAST_KNOWN_CMD = 8'd3;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_CMD,
    ST_LEN,
    ST_DATA,
    ST_CKL,
    ST_CKH
  } rx_state_t;
endpackage

// File: rtl/cfr_chk.sv
module cfr_chk (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       odd_en,
  input  logic       even_en,
  input  logic [7:0] din,
  output logic [7:0] acc_odd,
  output logic [7:0] acc_even
);
  logic [7:0] odd_d, even_d;

  always_comb begin
    odd_d  = acc_odd;
    even_d = acc_even;
    if (clr) begin
      odd_d  = '0;
      even_d = '0;
    end else begin
      if (odd_en)  odd_d  = acc_odd ^ din;
      if (even_en) even_d = acc_even ^ din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_odd  <= '0;
      acc_even <= '0;
    end else begin
      acc_odd  <= odd_d;
      acc_even <= even_d;
    end
  end
endmodule

// File: rtl/cfr_buf.sv
module cfr_buf #(
  parameter int MAX_DATA = 60,
  parameter int IDX_W    = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            din,
  output logic [MAX_DATA*8-1:0] payload
);
  for (genvar g = 0; g < MAX_DATA; g++) begin : g_slot
    logic       sel;
    logic [7:0] slot_q;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_q <= '0;
      else if (clr) slot_q <= '0;
      else if (sel) slot_q <= din;
    end

    assign payload[8*g +: 8] = slot_q;
  end
endmodule

// File: rtl/cfr_fsm.sv
module cfr_fsm
  import cfr_pkg::*;
#(
  parameter int MAX_DATA = 60,
  parameter int IDX_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic [7:0]       acc_odd,
  input  logic [7:0]       acc_even,
  output rx_state_t        state,
  output logic [IDX_W-1:0] idx,
  output logic             frame_start,
  output logic             take_cmd,
  output logic             take_len,
  output logic             take_data,
  output logic             odd_en,
  output logic             even_en,
  output logic             done_pulse,
  output logic             err_pulse
);
  localparam logic [7:0] MAX_LEN = 8'(MAX_DATA);

  rx_state_t        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]       len_q, len_d;
  logic             low_ok_q, low_ok_d;
  logic             done_q, done_d, err_q, err_d;

  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    len_d       = len_q;
    low_ok_d    = low_ok_q;
    done_d      = 1'b0;
    err_d       = 1'b0;
    frame_start = 1'b0;
    take_cmd    = 1'b0;
    take_len    = 1'b0;
    take_data   = 1'b0;
    odd_en      = 1'b0;
    even_en     = 1'b0;
    case (state_q)
      ST_HUNT: if (in_valid && in_byte == START_BYTE) begin
        frame_start = 1'b1;
        state_d     = ST_CMD;
      end
      ST_CMD: if (in_valid) begin
        take_cmd = 1'b1;
        odd_en   = 1'b1;
        state_d  = ST_LEN;
      end
      ST_LEN: if (in_valid) begin
        if (in_byte > MAX_LEN) begin
          err_d   = 1'b1;
          state_d = ST_HUNT;
        end else begin
          take_len = 1'b1;
          even_en  = 1'b1;
          len_d    = in_byte;
          idx_d    = '0;
          state_d  = (in_byte == 8'd0) ? ST_CKL : ST_DATA;
        end
      end
      ST_DATA: if (in_valid) begin
        take_data = 1'b1;
        odd_en    = ~idx_q[0];
        even_en   = idx_q[0];
        idx_d     = idx_q + 1'b1;
        if (8'(idx_q) + 8'd1 == len_q) state_d = ST_CKL;
      end
      ST_CKL: if (in_valid) begin
        low_ok_d = (in_byte == ~acc_odd);
        state_d  = ST_CKH;
      end
      ST_CKH: if (in_valid) begin
        if (low_ok_q && in_byte == ~acc_even) done_d = 1'b1;
        else                                  err_d  = 1'b1;
        state_d = ST_HUNT;
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_HUNT;
      idx_q    <= '0;
      len_q    <= '0;
      low_ok_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      len_q    <= len_d;
      low_ok_q <= low_ok_d;
      done_q   <= done_d;
      err_q    <= err_d;
    end
  end

  assign state      = state_q;
  assign idx        = idx_q;
  assign done_pulse = done_q;
  assign err_pulse  = err_q;
endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx
  import cfr_pkg::*;
#(
  parameter int MAX_DATA = 60
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [7:0]            in_byte,
  output logic                  pkt_done,
  output logic                  pkt_err,
  output logic [7:0]            pkt_cmd,
  output logic [7:0]            pkt_len,
  output logic [MAX_DATA*8-1:0] pkt_payload,
  output logic                  pkt_unknown
);
  localparam int IDX_W = $clog2(MAX_DATA + 1);

  rx_state_t        state;
  logic [IDX_W-1:0] idx;
  logic             frame_start, take_cmd, take_len, take_data;
  logic             odd_en, even_en;
  logic [7:0]       acc_odd, acc_even;
  logic [7:0]       cmd_q, len_q;
  logic             unk_q;

  cfr_fsm #(.MAX_DATA(MAX_DATA), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .acc_odd(acc_odd), .acc_even(acc_even), .state(state), .idx(idx),
    .frame_start(frame_start), .take_cmd(take_cmd), .take_len(take_len),
    .take_data(take_data), .odd_en(odd_en), .even_en(even_en),
    .done_pulse(pkt_done), .err_pulse(pkt_err)
  );

  cfr_chk u_chk_acc (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .odd_en(odd_en),
    .even_en(even_en), .din(in_byte), .acc_odd(acc_odd), .acc_even(acc_even)
  );

  cfr_buf #(.MAX_DATA(MAX_DATA), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .wr_en(take_data),
    .wr_idx(idx), .din(in_byte), .payload(pkt_payload)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      len_q <= '0;
      unk_q <= 1'b0;
    end else if (frame_start) begin
      cmd_q <= '0;
      len_q <= '0;
      unk_q <= 1'b0;
    end else begin
      if (take_cmd) begin
        cmd_q <= in_byte;
        unk_q <= in_byte > LAST_KNOWN_CMD;
      end
      if (take_len) len_q <= in_byte;
    end
  end

  assign pkt_cmd     = cmd_q;
  assign pkt_len     = len_q;
  assign pkt_unknown = unk_q;
endmodule

// File: rtl/cmd_frame_rx_chk.sv
module cmd_frame_rx_chk
  import cfr_pkg::*;
#(
  parameter int MAX_DATA = 60
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_byte,
  input rx_state_t  state,
  input logic       pkt_done,
  input logic       pkt_err,
  input logic [7:0] pkt_cmd,
  input logic [7:0] pkt_len,
  input logic       pkt_unknown
);
  localparam logic [7:0] MAX_LEN = 8'(MAX_DATA);

  assert_hunt_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HUNT && !(in_valid && in_byte == START_BYTE)) |=> state == ST_HUNT);

  assert_done_from_ckh_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> $past(state) == ST_CKH);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);

  assert_done_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_done && pkt_err));

  assert_long_len_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LEN && in_valid && in_byte > MAX_LEN) |=> (pkt_err && state == ST_HUNT));

  assert_done_len_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> pkt_len <= MAX_LEN);

  assert_unknown_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (pkt_unknown == (pkt_cmd > LAST_KNOWN_CMD)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(state));
endmodule

bind cmd_frame_rx cmd_frame_rx_chk #(.MAX_DATA(MAX_DATA)) u_rx_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
  .state(state), .pkt_done(pkt_done), .pkt_err(pkt_err),
  .pkt_cmd(pkt_cmd), .pkt_len(pkt_len), .pkt_unknown(pkt_unknown)
);

// File: tb/cmd_frame_rx_test.sv
`timescale 1ns/1ps
module cmd_frame_rx_test;
  localparam int MAXD = 60;
  localparam int PW   = MAXD * 8;
  localparam int NVEC = 9;
  // cmd, len, seed, corrupt (0 none, 1 low check, 2 high check)
  localparam logic [7:0] VEC [NVEC][4] = '{
    '{8'h00, 8'd5,  8'h11, 8'd0},
    '{8'h01, 8'd1,  8'h01, 8'd0},
    '{8'h02, 8'd5,  8'hA0, 8'd0},
    '{8'h03, 8'd8,  8'h33, 8'd0},
    '{8'h07, 8'd3,  8'h44, 8'd0},
    '{8'h00, 8'd0,  8'h00, 8'd0},
    '{8'h02, 8'd4,  8'h5C, 8'd1},
    '{8'h01, 8'd6,  8'h9E, 8'd2},
    '{8'hFF, 8'd60, 8'h05, 8'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [7:0]    in_byte;
  logic          pkt_done, pkt_err, pkt_unknown;
  logic [7:0]    pkt_cmd, pkt_len;
  logic [PW-1:0] pkt_payload;

  int checks = 0;
  int errors = 0;
  logic [PW-1:0] exp_pl;

  always #5 clk = ~clk;

  cmd_frame_rx #(.MAX_DATA(MAXD)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .pkt_done(pkt_done), .pkt_err(pkt_err), .pkt_cmd(pkt_cmd),
    .pkt_len(pkt_len), .pkt_payload(pkt_payload), .pkt_unknown(pkt_unknown)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Sends one frame; leaves the bench at the negedge where the result is visible.
  task automatic send_pkt(input logic [7:0] cmd, input logic [7:0] len,
                          input logic [7:0] seed, input logic [7:0] bad,
                          input int gap);
    logic [7:0] odd, even, d;
    odd    = cmd;
    even   = len;
    exp_pl = '0;
    put(8'h82);             if (gap > 0) idle(gap);
    put(cmd);               if (gap > 0) idle(gap);
    put(len);               if (gap > 0) idle(gap);
    for (int i = 0; i < int'(len); i++) begin
      d = seed + 8'(i * 29);
      exp_pl[8*i +: 8] = d;
      if (i % 2 == 0) odd = odd ^ d;
      else            even = even ^ d;
      put(d);
      if (gap > 0) idle(gap);
    end
    put((~odd) ^ ((bad == 8'd1) ? 8'h01 : 8'h00));
    if (gap > 0) idle(gap);
    put((~even) ^ ((bad == 8'd2) ? 8'h10 : 8'h00));
  endtask

  task automatic expect_good(input logic [7:0] cmd, input logic [7:0] len, input string tag);
    check(pkt_done === 1'b1, {tag, " R6 done"}, PW'(pkt_done), PW'(1));
    check(pkt_err === 1'b0, {tag, " R6 err low"}, PW'(pkt_err), PW'(0));
    check(pkt_cmd === cmd, {tag, " R2 cmd"}, PW'(pkt_cmd), PW'(cmd));
    check(pkt_len === len, {tag, " R2 len"}, PW'(pkt_len), PW'(len));
    check(pkt_payload === exp_pl, {tag, " R2 R13 payload"}, pkt_payload, exp_pl);
    check(pkt_unknown === (cmd > 8'd3), {tag, " R10 unknown"},
          PW'(pkt_unknown), PW'(cmd > 8'd3));
  endtask

  task automatic expect_bad(input string tag);
    check(pkt_err === 1'b1, {tag, " R7 err"}, PW'(pkt_err), PW'(1));
    check(pkt_done === 1'b0, {tag, " R7 no done"}, PW'(pkt_done), PW'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_byte  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    check(pkt_done === 1'b0 && pkt_err === 1'b0, "R12 pulses low",
          PW'({pkt_done, pkt_err}), PW'(0));
    check(pkt_cmd === 8'd0 && pkt_len === 8'd0 && pkt_unknown === 1'b0,
          "R12 fields zero", PW'({pkt_cmd, pkt_len, pkt_unknown}), PW'(0));
    check(pkt_payload === '0, "R12 payload zero", pkt_payload, '0);

    // Table of frames; R3/R4 mismatch cases included, R9 zero length
    for (int v = 0; v < NVEC; v++) begin
      send_pkt(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 0);
      if (VEC[v][3] == 8'd0) expect_good(VEC[v][0], VEC[v][1], $sformatf("vec%0d R3 R4 R9", v));
      else expect_bad($sformatf("vec%0d R3 R4", v));
      idle(1);
      check(pkt_done === 1'b0 && pkt_err === 1'b0, $sformatf("vec%0d R6 single pulse", v),
            PW'({pkt_done, pkt_err}), PW'(0));
    end

    // R1: garbage before the marker
    put(8'h00); put(8'h55); put(8'hFF); put(8'h81);
    idle(1);
    check(pkt_done === 1'b0 && pkt_err === 1'b0, "R1 garbage ignored",
          PW'({pkt_done, pkt_err}), PW'(0));
    put(8'h13); put(8'h83);
    send_pkt(8'h01, 8'd2, 8'h20, 8'd0, 0);
    expect_good(8'h01, 8'd2, "R1 after garbage");
    idle(2);

    // R5: marker value inside the payload
    send_pkt(8'h02, 8'd3, 8'h82, 8'd0, 0);
    expect_good(8'h02, 8'd3, "R5 marker in data");
    idle(1);

    // R8: length 61 aborts, next frame still received back to back
    put(8'h82); put(8'h00); put(8'd61);
    check(pkt_err === 1'b1 && pkt_done === 1'b0, "R8 long length err",
          PW'({pkt_err, pkt_done}), PW'(2));
    send_pkt(8'h03, 8'd4, 8'h61, 8'd0, 0);
    expect_good(8'h03, 8'd4, "R8 recover");
    idle(1);

    // R11: idle gaps between every byte
    send_pkt(8'h00, 8'd7, 8'hC3, 8'd0, 3);
    expect_good(8'h00, 8'd7, "R11 gaps");
    idle(1);

    // R12: reset in mid-frame, then a clean short frame (R13 upper bytes zero)
    put(8'h82); put(8'h05); put(8'd10); put(8'hAA); put(8'h5A);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(pkt_cmd === 8'd0 && pkt_len === 8'd0 && pkt_payload === '0,
          "R12 mid-frame reset clears", PW'({pkt_cmd, pkt_len}), PW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    send_pkt(8'h02, 8'd2, 8'h0F, 8'd0, 0);
    expect_good(8'h02, 8'd2, "R12 R13 after reset");
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule